// File: doc/BRIEF.md
# Address-Range Watchpoint and Debug-Break Unit

This block sits beside a processor pipeline and watches two address streams every clock: the instruction-fetch address and the data-access address, the latter qualified as a load or a store. Four watchpoints each hold an inclusive address window and three match-enable bits. Each bit selects one access kind: fetch, load or store. When any enabled watchpoint sees an access inside its window, the block reacts in one of two ways, chosen by a debug-enable input. With debug disabled, it raises a one-cycle trap request toward the pipeline. With debug enabled, it halts the processor into debug mode.

Debug mode can also be forced from an asynchronous break pin. The pin passes through a two-flop synchroniser, and only its low-to-high transition counts. While in debug mode, a level flag stays high and all further hits and break edges are ignored. A resume pulse returns the processor to normal running. Each accepted event also reports the lowest-numbered hitting watchpoint and a mask of every watchpoint that hit, so that the debugger can tell what fired.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, `trap_req`, `halt_req`, `dbg_active` and `brk_entry` are 0, `hit_idx` is 0 and `hit_mask` is all zeros.
- R2: Watchpoint i matches address A only when `lo_i <= A <= hi_i`, where `lo_i` is slice i of `wp_lo` and `hi_i` is slice i of `wp_hi`. Both bounds are inclusive, and a window with `lo_i > hi_i` never matches.
- R3: Kind bit 0 of watchpoint i (`wp_kind[3*i]`) enables matching on `if_addr` when `if_valid` is 1. Bit 1 enables matching on `da_addr` for a load (`da_valid`=1, `da_write`=0). Bit 2 enables matching on `da_addr` for a store (`da_valid`=1, `da_write`=1). A fetch hit and a data hit in the same cycle both count.
- R4: With `dbg_en` low and debug mode inactive, a hit sampled at a clock edge sets `trap_req` for exactly the following cycle, and `dbg_active` stays 0.
- R5: With `dbg_en` high and debug mode inactive, a hit sampled at an edge sets `dbg_active` and a one-cycle `halt_req` in the following cycle. `trap_req` stays 0 and `brk_entry` reads 0.
- R6: On an accepted hit, `hit_mask` bit i shows whether watchpoint i hit, and `hit_idx` gives the lowest-numbered watchpoint that hit.
- R7: With `dbg_en` high, a rising edge on `brk_pin` enters debug mode. `dbg_active`, `halt_req` and `brk_entry` become 1 on the third clock edge after the pin rises, and `hit_mask` becomes 0. A pin held high does not trigger again.
- R8: With `dbg_en` low, `brk_pin` edges never enter debug mode.
- R9: While `dbg_active` is 1, hits change neither `trap_req`, `halt_req`, `hit_idx` nor `hit_mask`.
- R10: `resume` high at an edge while `dbg_active` is 1 clears `dbg_active` in the following cycle, and a hit in that same cycle is ignored. `resume` has no effect while `dbg_active` is 0.
- R11: When a hit and a synchronised break edge arrive at the same edge with `dbg_en` high, debug mode is entered and credited to the watchpoint: `brk_entry` is 0 and `hit_idx` and `hit_mask` describe the hit.
- R12: `dbg_active` stays 1 without limit until a resume is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dbg_en | input | 1 | 1: hits halt into debug mode; 0: hits raise traps, breaks ignored |
| brk_pin | input | 1 | Asynchronous external break request, rising edge active |
| resume | input | 1 | Leave debug mode |
| if_valid | input | 1 | Instruction fetch address valid |
| if_addr | input | AW | Instruction fetch address |
| da_valid | input | 1 | Data access valid |
| da_write | input | 1 | Data access is a store (1) or a load (0) |
| da_addr | input | AW | Data access address |
| wp_lo | input | NWP*AW | Lower window bounds, watchpoint i in slice i |
| wp_hi | input | NWP*AW | Upper window bounds, watchpoint i in slice i |
| wp_kind | input | NWP*3 | Per watchpoint: bit 0 fetch, bit 1 load, bit 2 store |
| trap_req | output | 1 | One-cycle debug trap request |
| halt_req | output | 1 | One-cycle pulse on entry to debug mode |
| dbg_active | output | 1 | Processor is in debug mode |
| brk_entry | output | 1 | Last debug entry came from the break pin |
| hit_idx | output | IW | Lowest-numbered watchpoint of the last accepted hit |
| hit_mask | output | NWP | All watchpoints of the last accepted hit |

## Verification
Two pairs of functions can land on the same clock edge. In the first pair, a watchpoint hit meets the synchronised break edge. The bench raises the pin, waits the two synchroniser edges, and presents a store hit in the cycle the edge becomes visible. The entry must then be credited to the watchpoint, with `brk_entry` at 0 and the expected index and mask. In the second pair, a resume meets a new hit while in debug mode. The bench then expects debug mode to drop with no trap or halt, and with the previous index and mask left intact. All index and mask expectations come from an arithmetic model of the windows, checked over every address and access kind in two overlapping configurations.

// File: rtl/dbgw_pkg.sv
// Package: shared types for the watchpoint and debug-break unit.
// Assumes the access-kind field is three bits: fetch in bit 0, load in bit 1, store in bit 2.
package dbgw_pkg;

    localparam int KIND_W = 3;

    // Per-watchpoint access-kind enables; fetch lands in bit 0 of the packed value.
    typedef struct packed {
        logic store;
        logic load;
        logic fetch;
    } wp_kind_t;

    // Processor run state as seen by the debug logic.
    typedef enum logic [0:0] {
        MODE_RUN   = 1'b0,
        MODE_DEBUG = 1'b1
    } dbg_mode_e;

endpackage

// File: rtl/dbgw_range_cmp.sv
// Module: one watchpoint comparator.
// Checks the fetch address and the data address against an inclusive window [lo, hi].
// Each check is gated by the matching access-kind enable. Purely combinational.
// Assumes the addresses are stable for the whole cycle in which their valid is high.
module dbgw_range_cmp
    import dbgw_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  wp_kind_t      kind,
    input  logic          if_valid,
    input  logic [AW-1:0] if_addr,
    input  logic          da_valid,
    input  logic          da_write,
    input  logic [AW-1:0] da_addr,
    output logic          hit
);

    logic if_in, da_in, da_kind_ok;

    // Window tests on both streams; lo > hi leaves both false.
    always_comb begin
        if_in      = (if_addr >= lo) && (if_addr <= hi);
        da_in      = (da_addr >= lo) && (da_addr <= hi);
        da_kind_ok = da_write ? kind.store : kind.load;
    end

    // Combine the window tests with the access-kind enables.
    always_comb begin
        hit = (if_valid && kind.fetch && if_in) ||
              (da_valid && da_kind_ok && da_in);
    end

endmodule

// File: rtl/dbgw_prio_enc.sv
// Module: lowest-index priority encoder.
// Reports the position of the lowest set request bit and whether any bit is set.
// Combinational. The index reads 0 when no bit is set.
module dbgw_prio_enc #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Scan from the top so that the lowest set bit writes last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        any = |req;
    end

endmodule

// File: rtl/dbgw_brk_sync.sv
// Module: break-pin synchroniser and rising-edge detector.
// Passes the asynchronous pin through SYNC flops, then compares with one more flop.
// Assumes SYNC >= 2. The rise output is high for one cycle per low-to-high pin transition.
module dbgw_brk_sync #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);

    logic [SYNC-1:0] chain_q;
    logic            last_q;

    // Shift the raw pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC-2:0], pin};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[SYNC-1];
    end

    // A rise is a synchronised 1 following a synchronised 0.
    always_comb rise = chain_q[SYNC-1] && !last_q;

endmodule

// File: rtl/dbgw_mode_ctl.sv
// Module: run/debug mode controller.
// Turns qualified hits and break edges into a trap pulse or a debug-mode entry.
// Holds debug mode until a resume arrives, and records the hit index and mask.
// Assumes its inputs are synchronous to clk. In debug mode, hits and break edges are dropped.
module dbgw_mode_ctl
    import dbgw_pkg::*;
#(
    parameter int NWP = 4,
    localparam int IW = (NWP > 1) ? $clog2(NWP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dbg_en,
    input  logic           hit_any,
    input  logic [IW-1:0]  hit_first,
    input  logic [NWP-1:0] hit_vec,
    input  logic           brk_rise,
    input  logic           resume,
    output logic           trap_req,
    output logic           halt_req,
    output logic           dbg_active,
    output logic           brk_entry,
    output logic [IW-1:0]  hit_idx,
    output logic [NWP-1:0] hit_mask
);

    dbg_mode_e mode_q;

    // Sequence the mode and the reporting registers; a watchpoint outranks a break edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_RUN;
            trap_req  <= 1'b0;
            halt_req  <= 1'b0;
            brk_entry <= 1'b0;
            hit_idx   <= '0;
            hit_mask  <= '0;
        end else begin
            trap_req <= 1'b0;
            halt_req <= 1'b0;
            case (mode_q)
                MODE_RUN: begin
                    if (hit_any) begin
                        hit_idx   <= hit_first;
                        hit_mask  <= hit_vec;
                        brk_entry <= 1'b0;
                        if (dbg_en) begin
                            mode_q   <= MODE_DEBUG;
                            halt_req <= 1'b1;
                        end else begin
                            trap_req <= 1'b1;
                        end
                    end else if (brk_rise && dbg_en) begin
                        mode_q    <= MODE_DEBUG;
                        halt_req  <= 1'b1;
                        brk_entry <= 1'b1;
                        hit_idx   <= '0;
                        hit_mask  <= '0;
                    end
                end
                MODE_DEBUG: begin
                    if (resume) mode_q <= MODE_RUN;
                end
                default: mode_q <= MODE_RUN;
            endcase
        end
    end

    // Debug-active is the registered mode itself.
    always_comb dbg_active = (mode_q == MODE_DEBUG);

endmodule

// File: rtl/dbg_watch_unit.sv
// Module: address-range watchpoint and debug-break unit (top).
// Compares the fetch and data address streams against NWP programmable windows.
// Prioritises the hits, synchronises the break pin and drives the run/debug controller.
// Assumes the watchpoint configuration inputs are quasi-static while matching is in use.
module dbg_watch_unit
    import dbgw_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NWP  = 4,
    parameter int SYNC = 2,
    localparam int IW  = (NWP > 1) ? $clog2(NWP) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dbg_en,
    input  logic                  brk_pin,
    input  logic                  resume,
    input  logic                  if_valid,
    input  logic [AW-1:0]         if_addr,
    input  logic                  da_valid,
    input  logic                  da_write,
    input  logic [AW-1:0]         da_addr,
    input  logic [NWP*AW-1:0]     wp_lo,
    input  logic [NWP*AW-1:0]     wp_hi,
    input  logic [NWP*KIND_W-1:0] wp_kind,
    output logic                  trap_req,
    output logic                  halt_req,
    output logic                  dbg_active,
    output logic                  brk_entry,
    output logic [IW-1:0]         hit_idx,
    output logic [NWP-1:0]        hit_mask
);

    logic [NWP-1:0] hit_vec;
    logic [IW-1:0]  hit_first;
    logic           hit_any;
    logic           brk_rise;

    // One comparator per watchpoint, each fed its slice of the flat configuration.
    for (genvar g = 0; g < NWP; g++) begin : g_wp
        dbgw_range_cmp #(.AW(AW)) u_cmp (
            .lo       (wp_lo[g*AW +: AW]),
            .hi       (wp_hi[g*AW +: AW]),
            .kind     (wp_kind_t'(wp_kind[g*KIND_W +: KIND_W])),
            .if_valid (if_valid),
            .if_addr  (if_addr),
            .da_valid (da_valid),
            .da_write (da_write),
            .da_addr  (da_addr),
            .hit      (hit_vec[g])
        );
    end

    dbgw_prio_enc #(.N(NWP)) u_prio (
        .req (hit_vec),
        .idx (hit_first),
        .any (hit_any)
    );

    dbgw_brk_sync #(.SYNC(SYNC)) u_brk (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (brk_pin),
        .rise  (brk_rise)
    );

    dbgw_mode_ctl #(.NWP(NWP)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .dbg_en     (dbg_en),
        .hit_any    (hit_any),
        .hit_first  (hit_first),
        .hit_vec    (hit_vec),
        .brk_rise   (brk_rise),
        .resume     (resume),
        .trap_req   (trap_req),
        .halt_req   (halt_req),
        .dbg_active (dbg_active),
        .brk_entry  (brk_entry),
        .hit_idx    (hit_idx),
        .hit_mask   (hit_mask)
    );

endmodule

// File: rtl/dbg_watch_unit_chk.sv
// Module: property checker for dbg_watch_unit, attached by bind below.
// Relates the block's ports across clock edges. Assumes synchronous active-low reset.
module dbg_watch_unit_chk #(
    parameter int AW   = 32,
    parameter int NWP  = 4,
    localparam int IW  = (NWP > 1) ? $clog2(NWP) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dbg_en,
    input logic           resume,
    input logic           trap_req,
    input logic           halt_req,
    input logic           dbg_active,
    input logic           brk_entry,
    input logic [IW-1:0]  hit_idx,
    input logic [NWP-1:0] hit_mask
);

    logic [NWP-1:0] below_idx;

    // Bits strictly below the reported index; they must all be clear in the mask.
    always_comb begin
        for (int i = 0; i < NWP; i++) below_idx[i] = (i < int'(hit_idx));
    end

    assert_trap_halt_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_req && halt_req));

    assert_halt_in_debug_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> dbg_active);

    assert_halt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |=> !halt_req);

    assert_trap_needs_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !$past(dbg_en));

    assert_no_trap_in_debug_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !$past(dbg_active));

    assert_entry_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_active) |-> $past(dbg_en));

    assert_resume_exits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_active && resume) |=> !dbg_active);

    assert_debug_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_active && !resume) |=> dbg_active);

    assert_lowest_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req || (halt_req && !brk_entry)) |-> (hit_mask[hit_idx] && ((hit_mask & below_idx) == '0)));

endmodule

bind dbg_watch_unit dbg_watch_unit_chk #(.AW(AW), .NWP(NWP)) u_chk (.*);

// File: tb/dbg_watch_unit_test.sv
module dbg_watch_unit_test;

    localparam int AW  = 8;
    localparam int NWP = 4;
    localparam int IW  = 2;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                dbg_en, brk_pin, resume;
    logic                if_valid, da_valid, da_write;
    logic [AW-1:0]       if_addr, da_addr;
    logic [NWP*AW-1:0]   wp_lo, wp_hi;
    logic [NWP*3-1:0]    wp_kind;
    logic                trap_req, halt_req, dbg_active, brk_entry;
    logic [IW-1:0]       hit_idx;
    logic [NWP-1:0]      hit_mask;

    int checks = 0;
    int errors = 0;

    logic [AW-1:0] m_lo [NWP];
    logic [AW-1:0] m_hi [NWP];
    logic [2:0]    m_kd [NWP];

    always #2 clk = ~clk;

    dbg_watch_unit #(.AW(AW), .NWP(NWP)) uut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic program_wp(input int i, input logic [AW-1:0] lo, input logic [AW-1:0] hi,
                              input logic [2:0] kd);
        m_lo[i] = lo; m_hi[i] = hi; m_kd[i] = kd;
        wp_lo[i*AW +: AW] = lo;
        wp_hi[i*AW +: AW] = hi;
        wp_kind[i*3 +: 3] = kd;
    endtask

    // Drive one cycle of stimulus, let one edge pass, return just after it with inputs idle.
    task automatic step(input logic iv, input logic [AW-1:0] ia, input logic dv, input logic dw,
                        input logic [AW-1:0] dadr, input logic res);
        if_valid = iv; if_addr = ia; da_valid = dv; da_write = dw; da_addr = dadr; resume = res;
        @(posedge clk);
        #1;
        if_valid = 1'b0; da_valid = 1'b0; da_write = 1'b0; resume = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    function automatic logic [NWP-1:0] exp_mask(input logic iv, input logic [AW-1:0] ia,
                                                 input logic dv, input logic dw,
                                                 input logic [AW-1:0] dadr);
        logic [NWP-1:0] m;
        for (int i = 0; i < NWP; i++) begin
            m[i] = (iv && m_kd[i][0] && ia >= m_lo[i] && ia <= m_hi[i]) ||
                   (dv && !dw && m_kd[i][1] && dadr >= m_lo[i] && dadr <= m_hi[i]) ||
                   (dv &&  dw && m_kd[i][2] && dadr >= m_lo[i] && dadr <= m_hi[i]);
        end
        return m;
    endfunction

    function automatic logic [IW-1:0] lowest(input logic [NWP-1:0] m);
        for (int i = 0; i < NWP; i++) if (m[i]) return IW'(i);
        return '0;
    endfunction

    // Every address under every access kind, debug disabled so each hit is a trap.
    task automatic sweep();
        for (int k = 0; k < 3; k++) begin
            for (int a = 0; a < (1 << AW); a++) begin
                logic iv, dv, dw;
                logic [NWP-1:0] m;
                iv = (k == 0); dv = (k != 0); dw = (k == 2);
                m = exp_mask(iv, AW'(a), dv, dw, AW'(a));
                step(iv, AW'(a), dv, dw, AW'(a), 1'b0);
                chk("R2 R3 R4 trap", trap_req, |m);
                chk("R4 no debug", dbg_active, 0);
                if (|m) begin
                    chk("R6 index", hit_idx, lowest(m));
                    chk("R6 mask", hit_mask, m);
                end
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NWP-1:0] m;
        rst_n = 1'b0; dbg_en = 1'b0; brk_pin = 1'b0; resume = 1'b0;
        if_valid = 1'b0; if_addr = '0; da_valid = 1'b0; da_write = 1'b0; da_addr = '0;
        wp_lo = '0; wp_hi = '0; wp_kind = '0;
        for (int i = 0; i < NWP; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_kd[i] = '0; end
        repeat (3) @(posedge clk);
        #1;
        chk("R1 trap", trap_req, 0);
        chk("R1 halt", halt_req, 0);
        chk("R1 active", dbg_active, 0);
        chk("R1 brk_entry", brk_entry, 0);
        chk("R1 idx", hit_idx, 0);
        chk("R1 mask", hit_mask, 0);
        rst_n = 1'b1;
        idle();

        // Configuration A: disjoint and overlapping windows, one empty (lo > hi).
        program_wp(0, 8'h10, 8'h1F, 3'b001);
        program_wp(1, 8'h18, 8'h30, 3'b011);
        program_wp(2, 8'h80, 8'h80, 3'b100);
        program_wp(3, 8'h40, 8'h20, 3'b111);
        sweep();
        // Fetch and load hits in the same cycle merge.
        m = exp_mask(1'b1, 8'h12, 1'b1, 1'b0, 8'h25);
        step(1'b1, 8'h12, 1'b1, 1'b0, 8'h25, 1'b0);
        chk("R3 both streams mask", hit_mask, m);
        chk("R3 both streams trap", trap_req, 1);

        // Configuration B: heavy overlap for priority.
        program_wp(0, 8'h30, 8'h3F, 3'b010);
        program_wp(1, 8'h00, 8'hFF, 3'b111);
        program_wp(2, 8'h20, 8'h5F, 3'b101);
        program_wp(3, 8'h35, 8'h35, 3'b111);
        sweep();

        // Halt entry from a fetch hit at 0x21: watchpoints 1 and 2.
        dbg_en = 1'b1;
        step(1'b1, 8'h21, 1'b0, 1'b0, '0, 1'b0);
        chk("R5 halt", halt_req, 1);
        chk("R5 active", dbg_active, 1);
        chk("R5 no trap", trap_req, 0);
        chk("R5 brk_entry", brk_entry, 0);
        chk("R6 idx", hit_idx, 1);
        chk("R6 mask", hit_mask, 4'b0110);
        idle();
        chk("R5 halt pulse", halt_req, 0);
        chk("R12 held", dbg_active, 1);
        step(1'b0, '0, 1'b1, 1'b0, 8'h30, 1'b0);
        chk("R9 no trap", trap_req, 0);
        chk("R9 no halt", halt_req, 0);
        chk("R9 idx kept", hit_idx, 1);
        chk("R9 mask kept", hit_mask, 4'b0110);
        for (int n = 0; n < 6; n++) begin
            idle();
            chk("R12 held", dbg_active, 1);
        end
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1);
        chk("R10 resume", dbg_active, 0);
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1);
        chk("R10 resume idle", dbg_active, 0);
        chk("R10 resume idle halt", halt_req, 0);
        dbg_en = 1'b0;
        step(1'b1, 8'h35, 1'b0, 1'b0, '0, 1'b0);
        chk("R10 trap after idle resume", trap_req, 1);
        chk("R6 idx", hit_idx, 1);
        chk("R6 mask", hit_mask, 4'b1110);

        // Break-pin entry: visible on the third edge after the pin rises.
        dbg_en = 1'b1;
        brk_pin = 1'b1;
        idle();
        chk("R7 sync stage 1", dbg_active, 0);
        idle();
        chk("R7 sync stage 2", dbg_active, 0);
        idle();
        chk("R7 entry", dbg_active, 1);
        chk("R7 halt", halt_req, 1);
        chk("R7 brk_entry", brk_entry, 1);
        chk("R7 mask", hit_mask, 0);
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1);
        chk("R10 resume", dbg_active, 0);
        for (int n = 0; n < 5; n++) begin
            idle();
            chk("R7 level no retrigger", dbg_active, 0);
        end
        brk_pin = 1'b0;
        repeat (3) idle();

        // Break with debug disabled.
        dbg_en = 1'b0;
        brk_pin = 1'b1;
        for (int n = 0; n < 5; n++) begin
            idle();
            chk("R8 active", dbg_active, 0);
            chk("R8 halt", halt_req, 0);
        end
        brk_pin = 1'b0;
        repeat (3) idle();

        // Hit and break edge on the same edge: watchpoint credited.
        dbg_en = 1'b1;
        brk_pin = 1'b1;
        idle();
        idle();
        chk("R11 before", dbg_active, 0);
        step(1'b0, '0, 1'b1, 1'b1, 8'h40, 1'b0);
        chk("R11 active", dbg_active, 1);
        chk("R11 halt", halt_req, 1);
        chk("R11 brk_entry", brk_entry, 0);
        chk("R11 idx", hit_idx, 1);
        chk("R11 mask", hit_mask, 4'b0110);
        chk("R11 trap", trap_req, 0);
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b1);
        brk_pin = 1'b0;
        repeat (3) idle();

        // Resume and hit on the same edge: hit ignored.
        step(1'b1, 8'h21, 1'b0, 1'b0, '0, 1'b0);
        chk("R5 re-entry", dbg_active, 1);
        step(1'b1, 8'h35, 1'b0, 1'b0, '0, 1'b1);
        chk("R10 resume wins", dbg_active, 0);
        chk("R10 no trap", trap_req, 0);
        chk("R10 no halt", halt_req, 0);
        chk("R10 mask kept", hit_mask, 4'b0110);
        idle();
        chk("R10 stays out", dbg_active, 0);
        chk("R10 no late halt", halt_req, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule